// File: doc/BRIEF.md
# Motor Drive Protection Supervisor

This block watches the run controls of a three-phase motor predriver together with its protection conditions and raises output-disable requests. It combines four guards: a start-up hold-off that keeps every output off until a number of slow reference ticks have passed, a stall guard that times how long the speed loop stays out of lock, a reference-clock watchdog, and pass-through handling of the thermal and supply-undervoltage fault flags.

The stall and clock watchdogs only operate in the drive state. The drive state means that stop is released, brake is released and the start-up hold-off has ended. A stall is latched. It is cleared only by holding stop or brake for a minimum number of system clocks and then releasing it, or by a reset. The clock watchdog limit is the stall time divided by a ratio, and it recovers on its own when reference edges return. While clock loss, overheating or undervoltage is present, the stall timer is frozen rather than restarted.

Every input is synchronous to `clk`. `ref_edge` and `slow_tick` are single-cycle pulses produced upstream.

Top module: `drive_guard`

## Requirements
- R1: After reset, `all_off` is 1 until INIT_TICKS `slow_tick` pulses have been counted. It falls in the cycle after the last of those pulses. No stall or clock-loss timing runs during this interval.
- R2: The drive state is defined as hold-off over, `stop_req`=0 and `brake_req`=0. Outside the drive state, `lowside_off` is 0.
- R3: In the drive state, with `locked`=0 and no other protection active, `stall_latched` and `lowside_off` become 1 after STALL_TICKS counted `slow_tick` pulses, in the cycle after the last pulse. After STALL_TICKS-1 pulses they are still 0.
- R4: The stall count restarts at zero whenever `locked` is 1 or the drive state is left.
- R5: A latched stall clears when `stop_req` is held for at least HOLD_CYCLES clocks and then released. The latch is 0 in the cycle after the first low cycle. A shorter hold leaves the latch set.
- R6: The same clearing rule, including the rejection of short holds, applies to `brake_req`.
- R7: In the drive state, `lowside_off` rises after STALL_TICKS/LOSS_DIV `slow_tick` pulses with no `ref_edge`. It falls in the cycle after a `ref_edge`, and nothing is latched.
- R8: The stall count holds its value, without counting and without restarting, while clock loss, `over_temp` or `under_volt` is active.
- R9: `over_temp` in the drive state sets `lowside_off` in the same cycle. `under_volt` sets `all_off` in the same cycle, in any state.
- R10: `stall_latched` is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power cycle) |
| stop_req | input | 1 | 1 = stop mode |
| brake_req | input | 1 | 1 = brake applied |
| locked | input | 1 | 1 = speed loop inside lock range |
| ref_edge | input | 1 | One-cycle pulse per reference clock edge |
| slow_tick | input | 1 | One-cycle pulse per slow oscillator period |
| over_temp | input | 1 | Thermal shutdown flag |
| under_volt | input | 1 | Supply undervoltage flag |
| lowside_off | output | 1 | Request to turn off all low-side drivers |
| all_off | output | 1 | Request to turn off every output |
| stall_latched | output | 1 | Latched stall indicator |

## Verification
Directed sequences walk the stall timer to exactly one tick short of and exactly at its limit. They contrast a relock restart (R4) with a protection freeze (R8): a freeze resumes from the held count, while a restart begins again from zero. Stop and brake pulses one cycle short of the hold length, and then at the hold length, show whether clearing checks the duration. A reference-clock gap of the limit length is shown to recover without latching. A constrained-random phase then mixes control toggles, lock changes, sparse edges and fault flags against a cycle model in the bench.

// File: rtl/drive_guard.sv
module drive_guard #(
  parameter int STALL_TICKS = 3400,
  parameter int LOSS_DIV    = 34,
  parameter int HOLD_CYCLES = 50000,
  parameter int INIT_TICKS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic brake_req,
  input  logic locked,
  input  logic ref_edge,
  input  logic slow_tick,
  input  logic over_temp,
  input  logic under_volt,
  output logic lowside_off,
  output logic all_off,
  output logic stall_latched
);
  localparam int LOSS_LIMIT = (STALL_TICKS / LOSS_DIV) < 1 ? 1 : (STALL_TICKS / LOSS_DIV);
  localparam int SW = $clog2(STALL_TICKS + 1);
  localparam int LW = $clog2(LOSS_LIMIT + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int IW = $clog2(INIT_TICKS + 1);

  logic [IW-1:0] init_cnt;
  logic [LW-1:0] loss_cnt;
  logic [SW-1:0] stall_cnt;
  logic          stall_q;
  logic [1:0]    rel_in;
  logic [1:0]    rel_hit;

  wire init_active = init_cnt != IW'(INIT_TICKS);
  wire drive       = !init_active && !stop_req && !brake_req;
  wire clk_lost    = drive && (loss_cnt == LW'(LOSS_LIMIT));
  wire stall_run   = drive && !locked && !clk_lost && !over_temp && !under_volt && !stall_q;

  assign rel_in        = {brake_req, stop_req};
  assign all_off       = init_active || under_volt;
  assign lowside_off   = drive && (stall_q || clk_lost || over_temp);
  assign stall_latched = stall_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        init_cnt <= '0;
    else if (init_active && slow_tick) init_cnt <= init_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      loss_cnt <= '0;
    else if (!drive || ref_edge)     loss_cnt <= '0;
    else if (slow_tick && !clk_lost) loss_cnt <= loss_cnt + 1'b1;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_rel
      logic [HW-1:0] hold;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                          hold <= '0;
        else if (!rel_in[g])                 hold <= '0;
        else if (hold != HW'(HOLD_CYCLES))   hold <= hold + 1'b1;
      assign rel_hit[g] = !rel_in[g] && (hold == HW'(HOLD_CYCLES));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stall_cnt <= '0;
      stall_q   <= 1'b0;
    end else begin
      if (|rel_hit) stall_q <= 1'b0;
      if (!drive || locked)
        stall_cnt <= '0;
      else if (slow_tick && stall_run) begin
        if (stall_cnt == SW'(STALL_TICKS - 1)) begin
          stall_cnt <= '0;
          stall_q   <= 1'b1;
        end else
          stall_cnt <= stall_cnt + 1'b1;
      end
    end
endmodule

// File: rtl/drive_guard_chk.sv
module drive_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic brake_req,
  input logic locked,
  input logic slow_tick,
  input logic over_temp,
  input logic under_volt,
  input logic lowside_off,
  input logic all_off,
  input logic stall_latched
);
  // R9
  uv_alloff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    under_volt |-> all_off);

  // R2
  idle_lowside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req || brake_req) |-> !lowside_off);

  // R3
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_latched) |-> $past(!locked && !stop_req && !brake_req && slow_tick && !over_temp && !under_volt));

  // R5
  stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_latched) |-> ($past(!stop_req || !brake_req) && ($past(stop_req, 2) || $past(brake_req, 2))));

  // R9
  ot_lowside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over_temp && !stop_req && !brake_req && !all_off) |-> lowside_off);
endmodule

bind drive_guard drive_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .brake_req(brake_req),
  .locked(locked), .slow_tick(slow_tick), .over_temp(over_temp),
  .under_volt(under_volt), .lowside_off(lowside_off), .all_off(all_off),
  .stall_latched(stall_latched)
);

// File: tb/drive_guard_tb.sv
module drive_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STALL = 68;
  localparam int DIV   = 34;
  localparam int LOSS  = STALL / DIV;
  localparam int HOLD  = 8;
  localparam int INIT  = 3;

  logic clk = 0, rst_n = 0;
  logic stop_req = 0, brake_req = 0, locked = 0, ref_edge = 1, slow_tick = 0;
  logic over_temp = 0, under_volt = 0;
  logic lowside_off, all_off, stall_latched;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_guard #(.STALL_TICKS(STALL), .LOSS_DIV(DIV), .HOLD_CYCLES(HOLD), .INIT_TICKS(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .brake_req(brake_req), .locked(locked),
    .ref_edge(ref_edge), .slow_tick(slow_tick), .over_temp(over_temp), .under_volt(under_volt),
    .lowside_off(lowside_off), .all_off(all_off), .stall_latched(stall_latched));

  // Cycle model written from the requirements
  int m_init, m_loss, m_stall, m_sh, m_bh;
  logic m_lat;
  function automatic logic m_drive();
    return (m_init == INIT) && !stop_req && !brake_req;
  endfunction
  function automatic logic m_lost();
    return m_drive() && (m_loss == LOSS);
  endfunction
  function automatic logic exp_low();
    return m_drive() && (m_lat || m_lost() || over_temp);
  endfunction
  function automatic logic exp_all();
    return (m_init != INIT) || under_volt;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init <= 0; m_loss <= 0; m_stall <= 0; m_sh <= 0; m_bh <= 0; m_lat <= 0;
    end else begin
      if (m_init != INIT && slow_tick) m_init <= m_init + 1;
      if (!m_drive() || ref_edge) m_loss <= 0;
      else if (slow_tick && !m_lost()) m_loss <= m_loss + 1;
      m_sh <= stop_req  ? (m_sh < HOLD ? m_sh + 1 : m_sh) : 0;
      m_bh <= brake_req ? (m_bh < HOLD ? m_bh + 1 : m_bh) : 0;
      if ((!stop_req && m_sh == HOLD) || (!brake_req && m_bh == HOLD)) m_lat <= 0;
      if (!m_drive() || locked) m_stall <= 0;
      else if (slow_tick && !m_lost() && !over_temp && !under_volt && !m_lat) begin
        if (m_stall == STALL - 1) begin m_stall <= 0; m_lat <= 1; end
        else m_stall <= m_stall + 1;
      end
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1; cyc(); slow_tick = 0;
    end
  endtask

  task automatic pulse_stop(int n);
    stop_req = 1; cyc(n); stop_req = 0; cyc();
  endtask

  task automatic pulse_brake(int n);
    brake_req = 1; cyc(n); brake_req = 0; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    check("R10", "stall in reset", stall_latched, 0);
    rst_n = 1; cyc();
    check("R1", "all_off after reset", all_off, 1);
    check("R2", "lowside during init", lowside_off, 0);
    ticks(INIT - 1);
    check("R1", "all_off one tick short", all_off, 1);
    ticks(1);
    check("R1", "all_off after hold-off", all_off, 0);

    ticks(STALL - 1);
    check("R3", "stall one short", stall_latched, 0);
    ticks(1);
    check("R3", "stall at limit", stall_latched, 1);
    check("R3", "lowside on stall", lowside_off, 1);

    pulse_stop(HOLD - 1);
    check("R5", "short stop ignored", stall_latched, 1);
    stop_req = 1; cyc();
    check("R2", "lowside in stop", lowside_off, 0);
    cyc(HOLD - 1); stop_req = 0; cyc();
    check("R5", "stop hold clears", stall_latched, 0);

    ticks(40); locked = 1; cyc(); locked = 0;
    ticks(STALL - 1);
    check("R4", "relock restarts timer", stall_latched, 0);
    ticks(1);
    check("R4", "latched after restart", stall_latched, 1);
    pulse_brake(HOLD - 1);
    check("R6", "short brake ignored", stall_latched, 1);
    pulse_brake(HOLD);
    check("R6", "brake hold clears", stall_latched, 0);

    ticks(60); over_temp = 1; cyc();
    check("R9", "over_temp lowside", lowside_off, 1);
    ticks(20); over_temp = 0; ticks(7);
    check("R8", "timer frozen not counting", stall_latched, 0);
    ticks(1);
    check("R8", "timer resumes count", stall_latched, 1);
    pulse_stop(HOLD);
    check("R5", "cleared again", stall_latched, 0);

    locked = 1; ref_edge = 0;
    ticks(LOSS - 1);
    check("R7", "no loss yet", lowside_off, 0);
    ticks(1);
    check("R7", "clock loss", lowside_off, 1);
    ref_edge = 1; cyc();
    check("R7", "clock return", lowside_off, 0);
    check("R7", "loss not latched", stall_latched, 0);

    under_volt = 1; #1;
    check("R9", "under_volt all_off", all_off, 1);
    cyc(); under_volt = 0; cyc();
    check("R9", "under_volt released", all_off, 0);

    // constrained random phase against the cycle model
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(99) < 3)  stop_req   = ~stop_req;
      if ($urandom_range(99) < 3)  brake_req  = ~brake_req;
      if ($urandom_range(99) < 4)  locked     = ~locked;
      if ($urandom_range(99) < 2)  over_temp  = ~over_temp;
      if ($urandom_range(99) < 2)  under_volt = ~under_volt;
      ref_edge  = ($urandom_range(99) < 20);
      slow_tick = ($urandom_range(99) < 40);
      if (i == 3000) begin rst_n = 0; cyc(); rst_n = 1; end
      cyc();
      check("R3", "random stall", stall_latched, m_lat);
      check("R7", "random lowside", lowside_off, exp_low());
      check("R1", "random all_off", all_off, exp_all());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule